// File: doc/BRIEF.md
# Event-Gated Fractional Count Enable Generator

This block produces the one-cycle count-enable strobe that advances a PWM slice counter. It picks its events from one of four sources: every clock, every clock while the measured input is high, each rising transition of that input, or each falling transition. It then thins that event stream with a fixed-point divisor that has an 8-bit integer part and a 4-bit fraction. A first-order sigma-delta accumulator spaces the surviving enables, so a fractional divisor gives a mix of short and long gaps whose average matches the divisor.

Software can trim the phase of a running slice by one count. An advance request inserts an extra enable into the next idle cycle. A retard request removes the next enable that would have been issued. Each request sets a pending bit that clears itself once the action is done, and both pending bits are visible at the ports so that software can poll them. A run input stops the slice and clears the accumulator. Slices started in the same cycle with the same settings therefore produce identical enable timing. The divisor fields and the mode come from the owning register block, which resets them to an integer of 1, a fraction of 0 and free-running mode.

Top module: `pwmCountEnable`

## Requirements
- R1: In mode 0, every clock while running is an event. With a divisor of 1.0 (integer 1, fraction 0), `countEn` is high in every cycle that follows a running cycle. `countEn` is registered, so it goes high one cycle after the cycle whose event produced it.
- R2: In mode 1, a cycle is an event only while `bIn` is high.
- R3: In mode 2, a cycle is an event when `bIn` is high and was low in the previous cycle.
- R4: In mode 3, a cycle is an event when `bIn` is low and was high in the previous cycle.
- R5: The divisor equals integer + fraction/16. An integer field of 0 stands for 256, so in mode 0 exactly one enable is issued per 256 clocks.
- R6: Each event adds 16 to an accumulator. When the sum reaches 16×divisor, that event produces an enable and 16×divisor is subtracted. With a divisor of 2.5, enables fall on the 3rd, 5th, 8th and 10th events after start.
- R7: While `runEn` is low, no enable is produced and the accumulator returns to 0.
- R8: A pending advance, with no retard pending, forces an enable in the first running cycle that would otherwise produce none. It then clears.
- R9: A pending retard, with no advance pending, suppresses the first enable that a running cycle would produce. It then clears.
- R10: `advReq` and `retReq` set `advBusy` and `retBusy` one cycle later. A bit stays set until its action happens, for example while the slice is stopped or while no gap or no enable occurs.
- R11: If both bits are pending together, neither acts and both clear at the next clock edge.
- R12: After reset, `countEn`, `advBusy` and `retBusy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Slice run; low stops enables and clears the accumulator |
| bIn | input | 1 | Measured input, already synchronized to clk |
| mode | input | 2 | Event source: 0 free, 1 high level, 2 rising, 3 falling |
| divInt | input | 8 | Integer part of divisor, 0 means 256 |
| divFrac | input | 4 | Fractional part of divisor in sixteenths |
| advReq | input | 1 | One-cycle request to insert one enable |
| retReq | input | 1 | One-cycle request to delete one enable |
| countEn | output | 1 | Count-enable strobe for the slice counter |
| advBusy | output | 1 | Advance request pending |
| retBusy | output | 1 | Retard request pending |

## Verification
The assertions check the local rules on every cycle: a stopped slice gives no enable, a 1.0 free-running divisor enables every cycle, a request sets its busy bit, insertion and deletion act when their opportunity arrives, and a double request cancels. The sigma-delta gap pattern, the divide-by-256 encoding and the edge and level event selection span many cycles. Only the bench's behavioural model and its window counts show these, under toggling inputs and changing divisors.

// File: rtl/cen_pkg.sv
package cen_pkg;

  typedef enum logic [1:0] {
    EV_FREE = 2'd0,
    EV_HIGH = 2'd1,
    EV_RISE = 2'd2,
    EV_FALL = 2'd3
  } evMode_t;

  typedef struct packed {
    logic insertPulse;
    logic deletePulse;
  } phaseStrobe_t;

endpackage

// File: rtl/cenDatapath.sv
module cenDatapath
  import cen_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              bIn,
  input  evMode_t           mode,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  phaseStrobe_t      strobes,
  output logic              rawEn,
  output logic              countEn
);

  localparam int DIV_W = INT_W + FRAC_W + 1;
  localparam logic [DIV_W-1:0] STEP = DIV_W'(1) << FRAC_W;

  logic              bDly;
  logic              eventHit;
  logic [INT_W:0]    intPart;
  logic [DIV_W-1:0]  divisor;
  logic [DIV_W-1:0]  acc;
  logic [DIV_W-1:0]  accSum;
  logic              reachDiv;
  logic              finalEn;

  // event selection
  always_comb begin
    unique case (mode)
      EV_FREE: eventHit = 1'b1;
      EV_HIGH: eventHit = bIn;
      EV_RISE: eventHit = bIn & ~bDly;
      EV_FALL: eventHit = ~bIn & bDly;
      default: eventHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) bDly <= 1'b0;
    else       bDly <= bIn;
  end

  // divisor in sixteenths, zero integer meaning full range
  always_comb begin
    intPart  = (divInt == '0) ? {1'b1, {INT_W{1'b0}}} : {1'b0, divInt};
    divisor  = {intPart, divFrac};
    accSum   = acc + STEP;
    reachDiv = (accSum >= divisor);
    rawEn    = runEn & eventHit & reachDiv;
  end

  // first-order sigma-delta accumulator
  always_ff @(posedge clk) begin
    if (!rstN || !runEn) begin
      acc <= '0;
    end else if (eventHit) begin
      acc <= reachDiv ? (accSum - divisor) : accSum;
    end
  end

  // phase trim merge and registered output
  always_comb begin
    finalEn = runEn & ((rawEn & ~strobes.deletePulse) | strobes.insertPulse);
  end

  always_ff @(posedge clk) begin
    if (!rstN) countEn <= 1'b0;
    else       countEn <= finalEn;
  end

endmodule

// File: rtl/cenControl.sv
module cenControl
  import cen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         runEn,
  input  logic         rawEn,
  input  logic         advReq,
  input  logic         retReq,
  output phaseStrobe_t strobes,
  output logic         advBusy,
  output logic         retBusy
);

  logic advPend;
  logic retPend;
  logic bothPend;

  always_comb begin
    bothPend            = advPend & retPend;
    strobes.insertPulse = runEn & advPend & ~retPend & ~rawEn;
    strobes.deletePulse = runEn & retPend & ~advPend & rawEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      advPend <= 1'b0;
      retPend <= 1'b0;
    end else begin
      advPend <= advReq | (advPend & ~bothPend & ~strobes.insertPulse);
      retPend <= retReq | (retPend & ~bothPend & ~strobes.deletePulse);
    end
  end

  assign advBusy = advPend;
  assign retBusy = retPend;

endmodule

// File: rtl/pwmCountEnable.sv
module pwmCountEnable
  import cen_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              bIn,
  input  logic [1:0]        mode,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic              advReq,
  input  logic              retReq,
  output logic              countEn,
  output logic              advBusy,
  output logic              retBusy
);

  phaseStrobe_t strobes;
  logic         rawEn;

  cenDatapath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .bIn     (bIn),
    .mode    (evMode_t'(mode)),
    .divInt  (divInt),
    .divFrac (divFrac),
    .strobes (strobes),
    .rawEn   (rawEn),
    .countEn (countEn)
  );

  cenControl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .rawEn   (rawEn),
    .advReq  (advReq),
    .retReq  (retReq),
    .strobes (strobes),
    .advBusy (advBusy),
    .retBusy (retBusy)
  );

endmodule

// File: rtl/pwmCountEnableChecker.sv
module pwmCountEnableChecker #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic [1:0]        mode,
  input logic [INT_W-1:0]  divInt,
  input logic [FRAC_W-1:0] divFrac,
  input logic              advReq,
  input logic              retReq,
  input logic              rawEn,
  input logic              countEn,
  input logic              advBusy,
  input logic              retBusy
);

  assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !countEn);

  assert_unit_divisor_R1: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && mode == 2'd0 && divInt == INT_W'(1) && divFrac == '0 && !retBusy) |=> countEn);

  assert_adv_sets_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    advReq |=> advBusy);

  assert_ret_sets_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    retReq |=> retBusy);

  assert_insert_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (advBusy && !retBusy && runEn && !rawEn) |=> countEn);

  assert_delete_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (retBusy && !advBusy && runEn && rawEn) |=> !countEn);

  assert_both_cancel_R11: assert property (@(posedge clk) disable iff (!rstN)
    (advBusy && retBusy && !advReq && !retReq) |=> (!advBusy && !retBusy));

endmodule

bind pwmCountEnable pwmCountEnableChecker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .runEn   (runEn),
  .mode    (mode),
  .divInt  (divInt),
  .divFrac (divFrac),
  .advReq  (advReq),
  .retReq  (retReq),
  .rawEn   (rawEn),
  .countEn (countEn),
  .advBusy (advBusy),
  .retBusy (retBusy)
);

// File: tb/pwmCountEnable_bench.sv
module pwmCountEnable_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic       bIn = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] divInt = 8'd1;
  logic [3:0] divFrac = 4'd0;
  logic       advReq = 1'b0;
  logic       retReq = 1'b0;
  logic       countEn, advBusy, retBusy;

  int checks = 0;
  int fails = 0;
  string curReq = "R12";
  bit finished = 0;

  // behavioural reference state
  int  mAcc = 0;
  bit  mPrevB = 0, mAdv = 0, mRet = 0, mEn = 0;

  always #5 clk = ~clk;

  pwmCountEnable u_pwmCountEnable (
    .clk(clk), .rstN(rstN), .runEn(runEn), .bIn(bIn), .mode(mode),
    .divInt(divInt), .divFrac(divFrac), .advReq(advReq), .retReq(retReq),
    .countEn(countEn), .advBusy(advBusy), .retBusy(retBusy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced every clock, compared shortly after the edge
  always @(posedge clk) begin
    bit ev, raw, ins, del;
    int dv;
    if (!rstN) begin
      mAcc = 0; mPrevB = 0; mAdv = 0; mRet = 0; mEn = 0;
    end else begin
      case (mode)
        2'd0: ev = 1;
        2'd1: ev = bIn;
        2'd2: ev = bIn && !mPrevB;
        default: ev = !bIn && mPrevB;
      endcase
      dv = ((divInt == 0) ? 256 : int'(divInt)) * 16 + int'(divFrac);
      raw = 0;
      if (!runEn) mAcc = 0;
      else if (ev) begin
        if (mAcc + 16 >= dv) begin raw = 1; mAcc = mAcc + 16 - dv; end
        else mAcc = mAcc + 16;
      end
      ins = runEn && mAdv && !mRet && !raw;
      del = runEn && mRet && !mAdv && raw;
      mEn = runEn && ((raw && !del) || ins);
      begin
        bit nA, nR;
        nA = advReq || (mAdv && !mRet && !ins);
        nR = retReq || (mRet && !mAdv && !del);
        mAdv = nA; mRet = nR;
      end
      mPrevB = bIn;
    end
    #2;
    check(countEn == mEn, {curReq, " countEn"}, countEn, mEn);
    check(advBusy == mAdv && retBusy == mRet, {curReq, " busy"},
          {advBusy, retBusy}, {mAdv, mRet});
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countWindow(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (countEn) cnt++;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int cnt;
    cyc(4);
    curReq = "R12";
    check(countEn == 0 && advBusy == 0 && retBusy == 0, "R12 reset outputs",
          {countEn, advBusy, retBusy}, 0);
    rstN = 1;
    cyc(2);

    // R1: free-running, divisor 1.0
    curReq = "R1";
    runEn = 1; mode = 0; divInt = 1; divFrac = 0;
    cyc(1);
    countWindow(20, cnt);
    check(cnt == 20, "R1 enables in 20 cycles", cnt, 20);

    // R6: fractional divisor 2.5
    curReq = "R6";
    runEn = 0; cyc(2);
    divInt = 2; divFrac = 8; runEn = 1;
    countWindow(10, cnt);
    check(cnt == 4, "R6 enables over 10 events at 2.5", cnt, 4);
    divInt = 3; divFrac = 4'd3; cyc(40);

    // R5: integer field 0 means 256
    curReq = "R5";
    runEn = 0; cyc(2);
    divInt = 0; divFrac = 0; runEn = 1;
    countWindow(522, cnt);
    check(cnt == 2, "R5 enables in 522 cycles at 256", cnt, 2);

    // R2: level gating
    curReq = "R2";
    divInt = 1; divFrac = 0; mode = 1;
    for (int i = 0; i < 60; i++) begin bIn = ($urandom % 3) != 0; cyc(1); end
    divInt = 2; divFrac = 4'd4;
    for (int i = 0; i < 60; i++) begin bIn = ($urandom % 2) != 0; cyc(1); end

    // R3: rising edges
    curReq = "R3";
    mode = 2; divInt = 1; divFrac = 0;
    for (int i = 0; i < 80; i++) begin bIn = ((i / 3) % 2) != 0; cyc(1); end
    divInt = 2;
    for (int i = 0; i < 60; i++) begin bIn = ((i / 2) % 2) != 0; cyc(1); end

    // R4: falling edges
    curReq = "R4";
    mode = 3; divInt = 1;
    for (int i = 0; i < 80; i++) begin bIn = ((i / 4) % 2) != 0; cyc(1); end
    divFrac = 4'd8;
    for (int i = 0; i < 60; i++) begin bIn = ((i / 2) % 2) != 0; cyc(1); end

    // R7: run toggling
    curReq = "R7";
    mode = 0; divInt = 3; divFrac = 0;
    for (int i = 0; i < 40; i++) begin runEn = ($urandom % 4) != 0; cyc(1); end
    runEn = 0; cyc(1);
    countWindow(10, cnt);
    check(cnt == 0, "R7 no enable while stopped", cnt, 0);

    // R8: advance at divisor 4
    curReq = "R8";
    divInt = 4; runEn = 1; advReq = 1;
    cyc(1); advReq = 0;
    countWindow(39, cnt);
    check(cnt == 11, "R8 one extra enable in 40 cycles", cnt, 11);
    check(advBusy == 0, "R8 advance cleared", advBusy, 0);

    // R9: retard at divisor 4
    curReq = "R9";
    runEn = 0; cyc(2);
    runEn = 1; retReq = 1;
    cyc(1); retReq = 0;
    countWindow(39, cnt);
    check(cnt == 9, "R9 one fewer enable in 40 cycles", cnt, 9);
    check(retBusy == 0, "R9 retard cleared", retBusy, 0);

    // R10: requests pending without opportunity
    curReq = "R10";
    mode = 2; bIn = 0; divInt = 1;
    retReq = 1; cyc(1); retReq = 0;
    cyc(20);
    check(retBusy == 1, "R10 retard pending without events", retBusy, 1);
    bIn = 1; cyc(3);
    check(retBusy == 0, "R10 retard cleared after edge", retBusy, 0);
    mode = 0; divInt = 1; divFrac = 0;
    advReq = 1; cyc(1); advReq = 0;
    cyc(20);
    check(advBusy == 1, "R10 advance pending at divisor 1.0", advBusy, 1);
    divInt = 2; cyc(4);
    check(advBusy == 0, "R10 advance cleared once gaps exist", advBusy, 0);
    runEn = 0; advReq = 1; cyc(1); advReq = 0; cyc(10);
    check(advBusy == 1, "R10 advance pending while stopped", advBusy, 1);
    runEn = 1; cyc(4);

    // R11: both together cancel
    curReq = "R11";
    advReq = 1; retReq = 1; cyc(1); advReq = 0; retReq = 0;
    cyc(2);
    check(advBusy == 0 && retBusy == 0, "R11 both cleared", {advBusy, retBusy}, 0);
    advReq = 1; cyc(1); advReq = 0; retReq = 1; cyc(1); retReq = 0;
    cyc(20);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule